// File: doc/BRIEF.md
# Two-of-Four Sparse Weight Compressor with Index-Select MAC

This block turns dense signed weight groups of four into a half-size form and runs dot products on that form. The compression path accepts one four-element weight group per cycle. It keeps the two elements of largest absolute magnitude, discards the other two, and emits the two kept values together with a 2-bit position for each. The emitted group therefore always holds two zeros' worth of savings against the original.

The MAC path takes a compressed group (two values, two positions) beside a dense activation group of four. Each stored position selects the matching activation. The block multiplies each selected activation with its kept weight and adds both products into a signed accumulator. A dense product of four elements needs four multiplies; this path needs two, so one group per cycle gives twice the useful rate of a dense datapath of the same multiplier count. A clear input restarts the sum between dot products.

Top module: `sp24_engine`

## Requirements
- R1: Every compressed group carries exactly two entries, and the entry positions are strictly ascending: `c_idx[1:0]` < `c_idx[3:2]`. Element i of `w_data` sits at bits [8i+7:8i], entry k of `c_vals` at bits [8k+7:8k], entry k of `c_idx` at bits [2k+1:2k].
- R2: The two kept entries are the two elements of largest absolute magnitude; each carries its original signed value and its position 0..3 within the group.
- R3: When magnitudes are equal, the element at the lower position ranks higher and is kept first.
- R4: A group with three or four zero elements still yields two entries; the missing entries are zero values taken from the lowest zero positions.
- R5: The compression path accepts a group when `w_valid` and `w_ready` are both high at a clock edge, and presents its result on `c_valid` in the next cycle; `w_ready` is low exactly when a result is held and `c_ready` is low, and a held result keeps its values until taken.
- R6: When `m_valid` is high and `m_clear` low, the accumulator at the next edge becomes its old value plus `m_vals[entry0]*m_act[m_idx[1:0]] + m_vals[entry1]*m_act[m_idx[3:2]]` as signed products, wrapping at 32 bits; with neither input high it holds. `m_act` element i sits at bits [8i+7:8i]. `m_ready` is always high.
- R7: `m_clear` sets the accumulator to zero at the next edge; if `m_valid` is high in the same cycle, the accumulator instead takes that group's product sum alone.
- R8: After reset, `c_valid` is low and `acc` is zero.
- R9: The most negative weight, -128, has magnitude 128 and outranks 127 and -127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| w_valid | input | 1 | Dense weight group offered |
| w_ready | output | 1 | Compression path can take a group |
| w_data | input | 32 | Four signed 8-bit weights |
| c_valid | output | 1 | Compressed group present |
| c_ready | input | 1 | Consumer takes the compressed group |
| c_vals | output | 16 | Two kept signed weights |
| c_idx | output | 4 | Two 2-bit positions of the kept weights |
| m_valid | input | 1 | Compressed group and activations offered to the MAC |
| m_ready | output | 1 | MAC can take a group (always high) |
| m_clear | input | 1 | Restart the accumulator |
| m_vals | input | 16 | Two signed compressed weights |
| m_idx | input | 4 | Two 2-bit positions |
| m_act | input | 32 | Four signed 8-bit activations |
| acc | output | 32 | Signed running sum |

## Verification
The bench builds the block with its default widths: 8-bit elements and a 32-bit accumulator. With 8-bit elements the magnitude extremes of -128 against 127 and -127 are directly reachable, as are exact ties and groups made mostly of zeros. Random streams biased toward zeros and small values reach ties often, and random backpressure on `c_ready` exercises held results. The MAC is checked every cycle against a running sum, including clear issued alone and clear issued together with a group.

// File: rtl/sp24_pkg.sv
// Shared constants for the two-of-four sparse engine.
// Assumes the group size and kept count are fixed by the sparsity pattern.
package sp24_pkg;
    localparam int GRP  = 4;
    localparam int KEEP = 2;
    localparam int IW   = $clog2(GRP);
    typedef logic [IW-1:0] pos_t;
endpackage

// File: rtl/sp24_prune.sv
// Combinational magnitude pruner: ranks the four elements of a group by
// absolute value (lower position wins a tie) and returns the two best,
// ordered by ascending position. Assumes two's-complement elements.
module sp24_prune
    import sp24_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [GRP*EW-1:0]  grp,
    output logic [KEEP*EW-1:0] vals,
    output logic [KEEP*IW-1:0] idx
);
    localparam int MW = EW + 1;

    logic [MW-1:0] mag  [GRP];
    logic [GRP-1:0] keep;

    genvar gi;
    generate
        for (gi = 0; gi < GRP; gi++) begin : g_rank
            logic signed [MW-1:0] ext;
            logic [GRP-1:0]       beaten;
            // absolute value, widened so the most negative input fits
            always_comb begin
                ext     = MW'($signed(grp[gi*EW +: EW]));
                mag[gi] = ext[MW-1] ? MW'(-ext) : MW'(ext);
            end
            // mark every element that outranks this one
            always_comb begin
                for (int j = 0; j < GRP; j++) begin
                    if (j < gi) beaten[j] = (mag[j] >= mag[gi]);
                    else if (j > gi) beaten[j] = (mag[j] > mag[gi]);
                    else beaten[j] = 1'b0;
                end
                keep[gi] = ($countones(beaten) < KEEP);
            end
        end
    endgenerate

    pos_t lo_pos, hi_pos;
    logic found;

    // pick lowest and highest kept positions
    always_comb begin
        lo_pos = '0;
        hi_pos = '0;
        found  = 1'b0;
        for (int i = 0; i < GRP; i++) begin
            if (keep[i]) begin
                if (!found) begin
                    lo_pos = pos_t'(i);
                    found  = 1'b1;
                end
                hi_pos = pos_t'(i);
            end
        end
    end

    // gather values for the chosen positions
    always_comb begin
        idx  = {hi_pos, lo_pos};
        vals = {grp[hi_pos*EW +: EW], grp[lo_pos*EW +: EW]};
    end
endmodule

// File: rtl/sp24_stage.sv
// One-deep valid/ready register for the compressed stream. Takes a new
// entry whenever it is empty or its content is being taken in the same
// cycle. Assumes the upstream holds data stable while not accepted.
module sp24_stage
    import sp24_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [KEEP*EW-1:0] in_vals,
    input  logic [KEEP*IW-1:0] in_idx,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [KEEP*EW-1:0] out_vals,
    output logic [KEEP*IW-1:0] out_idx
);
    // room when empty or draining this cycle
    assign in_ready = !out_valid || out_ready;

    // occupancy flag
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vals <= '0;
            out_idx  <= '0;
        end else if (in_ready && in_valid) begin
            out_vals <= in_vals;
            out_idx  <= in_idx;
        end
    end

    // R1
    idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx[IW-1:0] < out_idx[2*IW-1:IW]));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vals) && $stable(out_idx)));

    // R5
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/sp24_dot.sv
// Index-select multiply-accumulate: each stored position picks one of the
// four dense activations, two products are summed and added to a wrapping
// signed accumulator. Assumes ACCW holds at least one product sum.
module sp24_dot
    import sp24_pkg::*;
#(
    parameter int EW   = 8,
    parameter int ACCW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m_valid,
    input  logic               m_clear,
    input  logic [KEEP*EW-1:0] m_vals,
    input  logic [KEEP*IW-1:0] m_idx,
    input  logic [GRP*EW-1:0]  m_act,
    output logic [ACCW-1:0]    acc
);
    localparam int PW = 2 * EW;

    logic signed [ACCW-1:0] term [KEEP];
    logic signed [ACCW-1:0] grp_sum;

    genvar gk;
    generate
        for (gk = 0; gk < KEEP; gk++) begin : g_lane
            pos_t                 pos;
            logic signed [EW-1:0] wv, av;
            logic signed [PW-1:0] prod;
            // select activation by stored position and multiply
            always_comb begin
                pos     = m_idx[gk*IW +: IW];
                wv      = $signed(m_vals[gk*EW +: EW]);
                av      = $signed(m_act[pos*EW +: EW]);
                prod    = wv * av;
                term[gk] = ACCW'(prod);
            end
        end
    endgenerate

    // sum the lane products
    always_comb begin
        grp_sum = '0;
        for (int k = 0; k < KEEP; k++) grp_sum = grp_sum + term[k];
    end

    // accumulator update with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else if (m_clear) acc <= m_valid ? grp_sum : '0;
        else if (m_valid) acc <= acc + grp_sum;
    end

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_clear && !m_valid) |=> (acc == '0));

    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_clear && !m_valid) |=> $stable(acc));
endmodule

// File: rtl/sp24_engine.sv
// Top of the two-of-four sparse engine: a pruning compressor feeding a
// one-deep output register, and an independent index-select MAC.
// Assumes synchronous active-low reset and valid/ready on both streams.
module sp24_engine
    import sp24_pkg::*;
#(
    parameter int EW   = 8,
    parameter int ACCW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               w_valid,
    output logic               w_ready,
    input  logic [GRP*EW-1:0]  w_data,
    output logic               c_valid,
    input  logic               c_ready,
    output logic [KEEP*EW-1:0] c_vals,
    output logic [KEEP*IW-1:0] c_idx,
    input  logic               m_valid,
    output logic               m_ready,
    input  logic               m_clear,
    input  logic [KEEP*EW-1:0] m_vals,
    input  logic [KEEP*IW-1:0] m_idx,
    input  logic [GRP*EW-1:0]  m_act,
    output logic [ACCW-1:0]    acc
);
    logic [KEEP*EW-1:0] pr_vals;
    logic [KEEP*IW-1:0] pr_idx;

    sp24_prune #(.EW(EW)) u_prune (
        .grp  (w_data),
        .vals (pr_vals),
        .idx  (pr_idx)
    );

    sp24_stage #(.EW(EW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (w_valid),
        .in_ready  (w_ready),
        .in_vals   (pr_vals),
        .in_idx    (pr_idx),
        .out_valid (c_valid),
        .out_ready (c_ready),
        .out_vals  (c_vals),
        .out_idx   (c_idx)
    );

    // MAC accepts every cycle
    assign m_ready = 1'b1;

    sp24_dot #(.EW(EW), .ACCW(ACCW)) u_dot (
        .clk     (clk),
        .rst_n   (rst_n),
        .m_valid (m_valid),
        .m_clear (m_clear),
        .m_vals  (m_vals),
        .m_idx   (m_idx),
        .m_act   (m_act),
        .acc     (acc)
    );

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!c_valid && acc == '0));
endmodule

// File: tb/sp24_engine_tb.sv
module sp24_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        w_valid = 1'b0, c_ready = 1'b0;
    logic [31:0] w_data = '0;
    logic        w_ready, c_valid, m_ready;
    logic [15:0] c_vals;
    logic [3:0]  c_idx;
    logic        m_valid = 1'b0, m_clear = 1'b0;
    logic [15:0] m_vals = '0;
    logic [3:0]  m_idx = '0;
    logic [31:0] m_act = '0;
    logic [31:0] acc;

    int n_tests = 0, n_fail = 0, cycles = 0;

    always #4 clk = ~clk;

    sp24_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .c_valid(c_valid), .c_ready(c_ready), .c_vals(c_vals), .c_idx(c_idx),
        .m_valid(m_valid), .m_ready(m_ready), .m_clear(m_clear),
        .m_vals(m_vals), .m_idx(m_idx), .m_act(m_act), .acc(acc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference: two largest magnitudes, lower position on ties, ascending order
    function automatic logic [19:0] ref_comp(input logic [31:0] g);
        int m [4];
        int a, b, lo, hi;
        for (int i = 0; i < 4; i++) begin
            m[i] = int'($signed(g[8*i +: 8]));
            if (m[i] < 0) m[i] = -m[i];
        end
        a = 0;
        for (int i = 1; i < 4; i++) if (m[i] > m[a]) a = i;
        b = (a == 0) ? 1 : 0;
        for (int i = 0; i < 4; i++) if (i != a && m[i] > m[b]) b = i;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        return {g[8*hi +: 8], g[8*lo +: 8], 2'(hi), 2'(lo)};
    endfunction

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_up();
        end
    end

    task automatic direct(input logic [31:0] g, input logic [15:0] ev, input logic [3:0] ei, input string req);
        @(negedge clk);
        w_data = g; w_valid = 1'b1; c_ready = 1'b1;
        #1 check(w_ready, "R5 ready", 32'(w_ready), 32'd1);
        @(negedge clk);
        w_valid = 1'b0;
        #1;
        check(c_valid, "R5 latency", 32'(c_valid), 32'd1);
        check(c_vals == ev && c_idx == ei, req, {12'd0, c_vals, c_idx}, {12'd0, ev, ei});
    endtask

    logic [19:0] expq [$];

    initial begin
        bit acc_prev;
        int sent, got, n;
        logic [19:0] e;
        longint macc;
        logic signed [31:0] s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!c_valid, "R8 c_valid", 32'(c_valid), 32'd0);
        check(acc == 0, "R8 acc", acc, 32'd0);

        // element 0 in the low byte
        direct({8'sd5, 8'sd1, -8'sd7, 8'sd3},  {8'sd5, -8'sd7}, {2'd3, 2'd1}, "R2 largest kept");
        direct({8'sd2, 8'sd4, -8'sd4, 8'sd4},  {-8'sd4, 8'sd4}, {2'd1, 2'd0}, "R3 tie lower position");
        direct({8'sd0, 8'sd9, 8'sd0, 8'sd0},   {8'sd9, 8'sd0},  {2'd2, 2'd0}, "R4 mostly zero");
        direct(32'd0,                          16'd0,           {2'd1, 2'd0}, "R4 all zero");
        direct({8'sd0, -8'sd127, 8'sd127, -8'sd128}, {8'sd127, -8'sd128}, {2'd1, 2'd0}, "R9 most negative");
        direct({-8'sd3, 8'sd3, -8'sd3, 8'sd1}, {8'sd3, -8'sd3}, {2'd2, 2'd1}, "R3 signed tie");

        // random stream with backpressure
        @(negedge clk);
        c_ready = 1'b0;
        acc_prev = 1'b0; sent = 0; got = 0; n = 400;
        while (got < n) begin
            @(negedge clk);
            if (!w_valid || acc_prev) begin
                if (sent < n && ($urandom % 4) != 0) begin
                    for (int i = 0; i < 4; i++)
                        w_data[8*i +: 8] = (($urandom % 4) == 0) ? 8'd0 :
                                           (($urandom % 2) != 0) ? 8'($urandom) : 8'(($urandom % 5) - 2);
                    w_valid = 1'b1;
                end else w_valid = 1'b0;
            end
            c_ready = (($urandom % 3) != 0);
            #1;
            acc_prev = w_valid && w_ready;
            check(w_ready == (!c_valid || c_ready), "R5 ready rule", 32'(w_ready), 32'(!c_valid || c_ready));
            if (acc_prev) begin
                expq.push_back(ref_comp(w_data));
                sent++;
            end
            if (c_valid && c_ready) begin
                if (expq.size() == 0) check(1'b0, "R5 spurious output", 32'(c_valid), 32'd0);
                else begin
                    e = expq.pop_front();
                    check({c_vals, c_idx} == e, "R1 R2 R3 R4 stream", {12'd0, c_vals, c_idx}, {12'd0, e});
                    check(c_idx[1:0] < c_idx[3:2], "R1 order", 32'(c_idx), 32'(e[3:0]));
                end
                got++;
            end
        end
        @(negedge clk);
        w_valid = 1'b0; c_ready = 1'b0;

        // MAC: compare against a running sum every cycle
        macc = 0;
        for (int t = 0; t < 600; t++) begin
            @(negedge clk);
            check(m_ready, "R6 m_ready", 32'(m_ready), 32'd1);
            check(acc == 32'(macc), "R6 R7 acc", acc, 32'(macc));
            m_valid = (($urandom % 4) != 0);
            m_clear = (t == 5) || (t == 6) || (($urandom % 40) == 0);
            if (t == 6) m_valid = 1'b1;
            if (t == 5) m_valid = 1'b0;
            m_vals = (t < 20) ? {-8'sd128, -8'sd128} : 16'($urandom);
            m_idx  = 4'($urandom);
            m_act  = (t < 20) ? {4{-8'sd128}} : $urandom;
            #1;
            s = 32'(int'($signed(m_vals[7:0])) * int'($signed(m_act[8*m_idx[1:0] +: 8])) +
                    int'($signed(m_vals[15:8])) * int'($signed(m_act[8*m_idx[3:2] +: 8])));
            if (m_clear) macc = m_valid ? longint'(s) : 0;
            else if (m_valid) macc = macc + longint'(s);
            macc = longint'($signed(32'(macc)));
        end
        @(negedge clk);
        m_valid = 1'b0; m_clear = 1'b1;
        @(negedge clk);
        m_clear = 1'b0;
        #1 check(acc == 0, "R7 clear alone", acc, 32'd0);
        @(negedge clk);
        check(acc == 0, "R6 hold idle", acc, 32'd0);
        finish_up();
    end
endmodule